// File: doc/BRIEF.md
# Downstream Frame Aligner and Descrambler

This block takes the byte stream of a passive optical network downstream link, one byte per accepted cycle, and finds where each fixed-length frame begins. It searches the stream for a 32-bit synchronization word. It then confirms the alignment one frame later: the word must appear again at the frame interval, and the 30-bit superframe counter carried in the ident field must have advanced by exactly one. Once locked, it strips the frame-synchronous scrambling from everything after the sync word and hands the clear bytes downstream with a start-of-frame marker.

While locked, the block also watches link quality in two ways. A running byte-wise parity over the raw line bytes is compared with the parity byte carried in each frame, and the number of disagreeing bits is added to a counter. The 16-bit payload length word in the header is checked against its CRC-8, and a bad check is flagged and counted. A superframe counter that does not step by one while locked raises a one-cycle alarm. The frame length is a parameter: 19440 bytes suits the lower line rate and 38880 the higher one.

Frame layout, by byte offset counted from 0 at the first sync byte: 0-3 sync word, 4-7 ident word (big-endian, superframe counter in the low 30 bits), 8 parity byte, 9-10 length word (big-endian), 11 length CRC, then payload up to the frame length.

Top module: `ds_frame_sync`

## Requirements
- R1: After reset the block is unlocked, both error counters are zero, and out_valid, out_sof, ident_jump, len_strobe and len_crc_bad are low.
- R2: While hunting, the block matches 0xB6AB31E0 against the last four accepted bytes (0xB6 arriving first). A match moves it to a pre-lock state. It locks at the ident byte (offset 7) of the next frame only if the sync word is again present at offsets 0-3 and the low 30 bits of the descrambled ident word equal the previous frame's value plus one modulo 2^30; otherwise it returns to hunting.
- R3: While locked, a frame whose offsets 0-3 do not hold the sync word counts as a miss and a correct one clears the miss count; on the fifth consecutive miss the block unlocks at offset 3 of that frame.
- R4: While locked, every accepted byte appears on out_byte one cycle later with out_valid high; out_sof is high for offset 0 only; offsets 0-3 pass unchanged and offsets 4 onward are descrambled.
- R5: The descrambling key is produced by a 7-bit register preset to all ones for offset 4; for each bit the key bit is bit 6, after which the register shifts left taking bit6 XOR bit5 into bit 0; the first key bit of a byte is applied to its most significant bit.
- R6: While locked, from the second frame after lock onwards, the descrambled byte at offset 8 is compared with the XOR of all raw line bytes from offset 9 of the previous frame through offset 7 of the current one, and the number of differing bits is added to bip_err_cnt.
- R7: While locked, the length word (descrambled offsets 9-10, big-endian) is checked against descrambled offset 11 using CRC-8 with polynomial 0x07, initial value 0, most significant bit first. One cycle after offset 11, len_strobe pulses with len_value; on a mismatch len_crc_bad pulses with it and len_err_cnt increments.
- R8: While locked, ident_jump pulses one cycle after offset 7 when the low 30 bits of the ident word are not the previous value plus one (modulo 2^30); the new value becomes the reference, and the two upper ident bits never matter.
- R9: Both error counters saturate at their all-ones value instead of wrapping.
- R10: Cycles with in_valid low are ignored: they do not advance the frame position, the descrambler or the parity, and produce no output byte.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_byte holds a line byte this cycle |
| in_byte | input | 8 | Received line byte |
| out_valid | output | 1 | out_byte holds a byte of a locked frame |
| out_byte | output | 8 | Descrambled byte (sync bytes unchanged) |
| out_sof | output | 1 | out_byte is offset 0 of a frame |
| locked | output | 1 | Frame alignment is established |
| ident_jump | output | 1 | Superframe counter discontinuity pulse |
| len_strobe | output | 1 | len_value was just checked |
| len_value | output | 16 | Last extracted payload length word |
| len_crc_bad | output | 1 | The length word failed its CRC |
| bip_err_cnt | output | CNT_W | Saturating count of parity bit errors |
| len_err_cnt | output | CNT_W | Saturating count of bad length CRCs |

## Verification
The parity byte at offset 8 both closes one parity window and is the boundary at which the next window starts, so the comparison and the accumulator restart happen on the same accepted byte. The bench provokes this by corrupting the parity of one frame and sending a clean frame right after. The counter must rise by exactly the corrupted bit count and then stay put, which shows that the parity byte itself is kept out of the new window and that no error carries into it. A frame carrying both a parity error and a length CRC error is also sent, and each counter must move by its own amount.

// File: rtl/pon_ds_pkg.sv
`timescale 1ns/1ps
package pon_ds_pkg;

  localparam logic [31:0] SYNC_WORD = 32'hB6AB_31E0;
  localparam int OFS_SYNC_END  = 3;
  localparam int OFS_IDENT_END = 7;
  localparam int OFS_BIP       = 8;
  localparam int OFS_LEN_HI    = 9;
  localparam int OFS_LEN_LO    = 10;
  localparam int OFS_LEN_CRC   = 11;
  localparam int OFS_SCR_FIRST = 4;
  localparam int IDENT_W       = 30;

  typedef enum logic [1:0] {ST_HUNT, ST_PRESYNC, ST_SYNC} align_state_t;

  typedef struct packed {
    logic [7:0] key;
    logic [6:0] next;
  } scr_step_t;

  // Eight key bits from a 7-stage x^7+x^6+1 generator, MSB first.
  function automatic scr_step_t scr_step(input logic [6:0] cur);
    scr_step_t r;
    logic [6:0] s;
    r = '0;
    s = cur;
    for (int i = 7; i >= 0; i--) begin
      r.key[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    r.next = s;
    return r;
  endfunction

  // CRC-8, polynomial 0x07, zero preset, over a 16-bit word MSB first.
  function automatic logic [7:0] crc8_word(input logic [15:0] w);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 15; i >= 0; i--) begin
      fb = c[7] ^ w[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, b[i]};
    return n;
  endfunction

endpackage

// File: rtl/ds_align.sv
`timescale 1ns/1ps
module ds_align
  import pon_ds_pkg::*;
#(
  parameter int FRAME_BYTES = 19440,
  parameter int LOSS_MISSES = 5,
  localparam int POS_W  = $clog2(FRAME_BYTES),
  localparam int MISS_W = $clog2(LOSS_MISSES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       din,
  input  logic [7:0]       dsc,
  output align_state_t     state,
  output logic [POS_W-1:0] pos,
  output logic             sync_end,
  output logic             sync_miss,
  output logic             id_ok,
  output logic             id_jump
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BYTES - 1);

  logic [23:0]        raw_sh;
  logic [21:0]        dsc_sh;
  logic [IDENT_W-1:0] prev_id, cur_id;
  logic [MISS_W-1:0]  miss_cnt;
  logic               pre_seen;
  logic               match_now, at_sync, at_ident, id_seq, id_check;

  assign match_now = ({raw_sh, din} == SYNC_WORD);
  assign at_sync   = in_valid && (pos == POS_W'(OFS_SYNC_END));
  assign at_ident  = in_valid && (pos == POS_W'(OFS_IDENT_END));
  assign cur_id    = {dsc_sh, dsc};
  assign id_seq    = (cur_id == prev_id + IDENT_W'(1));

  assign sync_end  = in_valid && ((state == ST_HUNT) ? match_now : (pos == POS_W'(OFS_SYNC_END)));
  assign sync_miss = at_sync && (state != ST_HUNT) && !match_now;
  assign id_check  = at_ident && ((state == ST_SYNC) || (state == ST_PRESYNC && pre_seen));
  assign id_ok     = id_check && id_seq;
  assign id_jump   = at_ident && (state == ST_SYNC) && !id_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      pos      <= '0;
      raw_sh   <= '0;
      dsc_sh   <= '0;
      prev_id  <= '0;
      miss_cnt <= '0;
      pre_seen <= 1'b0;
    end else if (in_valid) begin
      raw_sh <= {raw_sh[15:0], din};
      dsc_sh <= {dsc_sh[13:0], dsc};
      if (state == ST_HUNT && match_now) pos <= POS_W'(OFS_SCR_FIRST);
      else if (pos == POS_LAST)          pos <= '0;
      else                               pos <= pos + 1'b1;

      case (state)
        ST_HUNT: begin
          if (match_now) begin
            state    <= ST_PRESYNC;
            pre_seen <= 1'b0;
            miss_cnt <= '0;
          end
        end
        ST_PRESYNC: begin
          if (pos == POS_W'(OFS_SYNC_END)) begin
            if (!match_now) state <= ST_HUNT;
            else            pre_seen <= 1'b1;
          end
          if (pos == POS_W'(OFS_IDENT_END)) begin
            if (!pre_seen) prev_id <= cur_id;
            else if (id_seq) begin
              state   <= ST_SYNC;
              prev_id <= cur_id;
            end else state <= ST_HUNT;
          end
        end
        ST_SYNC: begin
          if (pos == POS_W'(OFS_SYNC_END)) begin
            if (match_now) miss_cnt <= '0;
            else if (miss_cnt == MISS_W'(LOSS_MISSES - 1)) begin
              state    <= ST_HUNT;
              miss_cnt <= '0;
            end else miss_cnt <= miss_cnt + 1'b1;
          end
          if (pos == POS_W'(OFS_IDENT_END)) prev_id <= cur_id;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/ds_descrambler.sv
`timescale 1ns/1ps
module ds_descrambler
  import pon_ds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       restart,
  output logic [7:0] key
);

  logic [6:0] gen;
  scr_step_t  step;

  assign step = scr_step(gen);
  assign key  = step.key;

  always_ff @(posedge clk) begin
    if (rst)           gen <= 7'h7F;
    else if (in_valid) gen <= restart ? 7'h7F : step.next;
  end

endmodule

// File: rtl/ds_bip.sv
`timescale 1ns/1ps
module ds_bip
  import pon_ds_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       line_byte,
  input  logic             at_bip,
  input  logic             locked,
  input  logic [7:0]       rx_bip,
  output logic [CNT_W-1:0] err_cnt
);

  logic [7:0]     acc;
  logic           armed, cmp_now;
  logic [3:0]     bad_bits;
  logic [SUM_W-1:0] sum;

  assign cmp_now  = at_bip && locked && armed;
  assign bad_bits = ones8(acc ^ rx_bip);
  assign sum      = {1'b0, err_cnt} + SUM_W'(bad_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      armed   <= 1'b0;
      err_cnt <= '0;
    end else begin
      if (in_valid) acc <= at_bip ? 8'h00 : (acc ^ line_byte);
      if (!locked)     armed <= 1'b0;
      else if (at_bip) armed <= 1'b1;
      if (cmp_now) err_cnt <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/ds_frame_sync.sv
`timescale 1ns/1ps
module ds_frame_sync
  import pon_ds_pkg::*;
#(
  parameter int FRAME_BYTES = 19440,
  parameter int LOSS_MISSES = 5,
  parameter int CNT_W       = 16,
  localparam int POS_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_sof,
  output logic             locked,
  output logic             ident_jump,
  output logic             len_strobe,
  output logic [15:0]      len_value,
  output logic             len_crc_bad,
  output logic [CNT_W-1:0] bip_err_cnt,
  output logic [CNT_W-1:0] len_err_cnt
);

  align_state_t     st;
  logic [POS_W-1:0] pos;
  logic [7:0]       key, dsc, len_hi, len_lo, len_crc_exp;
  logic             ev_sync_end, ev_sync_miss, ev_id_ok, ev_id_jump;
  logic             in_sync, in_hdr, ev_len, len_bad_now;

  ds_align #(.FRAME_BYTES(FRAME_BYTES), .LOSS_MISSES(LOSS_MISSES)) u_align (
    .clk(clk), .rst(rst), .in_valid(in_valid), .din(in_byte), .dsc(dsc),
    .state(st), .pos(pos), .sync_end(ev_sync_end), .sync_miss(ev_sync_miss),
    .id_ok(ev_id_ok), .id_jump(ev_id_jump)
  );

  ds_descrambler u_dscr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .restart(ev_sync_end), .key(key)
  );

  assign dsc     = in_byte ^ key;
  assign in_sync = (st == ST_SYNC);
  assign locked  = in_sync;
  assign in_hdr  = (pos < POS_W'(OFS_SCR_FIRST));

  ds_bip #(.CNT_W(CNT_W)) u_bip (
    .clk(clk), .rst(rst), .in_valid(in_valid), .line_byte(in_byte),
    .at_bip(in_valid && pos == POS_W'(OFS_BIP)), .locked(in_sync),
    .rx_bip(dsc), .err_cnt(bip_err_cnt)
  );

  assign len_crc_exp = crc8_word({len_hi, len_lo});
  assign ev_len      = in_valid && in_sync && (pos == POS_W'(OFS_LEN_CRC));
  assign len_bad_now = ev_len && (len_crc_exp != dsc);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_byte    <= '0;
      out_sof     <= 1'b0;
      ident_jump  <= 1'b0;
      len_hi      <= '0;
      len_lo      <= '0;
      len_strobe  <= 1'b0;
      len_value   <= '0;
      len_crc_bad <= 1'b0;
      len_err_cnt <= '0;
    end else begin
      out_valid   <= in_valid && in_sync;
      out_sof     <= in_valid && in_sync && (pos == '0);
      if (in_valid) out_byte <= in_hdr ? in_byte : dsc;
      ident_jump  <= ev_id_jump;
      if (in_valid && pos == POS_W'(OFS_LEN_HI)) len_hi <= dsc;
      if (in_valid && pos == POS_W'(OFS_LEN_LO)) len_lo <= dsc;
      len_strobe  <= ev_len;
      len_crc_bad <= len_bad_now;
      if (ev_len) len_value <= {len_hi, len_lo};
      if (len_bad_now && len_err_cnt != {CNT_W{1'b1}}) len_err_cnt <= len_err_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ds_frame_sync_chk.sv
`timescale 1ns/1ps
module ds_frame_sync_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             locked,
  input logic             out_valid,
  input logic             out_sof,
  input logic             ident_jump,
  input logic             len_strobe,
  input logic             len_crc_bad,
  input logic [CNT_W-1:0] bip_err_cnt,
  input logic [CNT_W-1:0] len_err_cnt,
  input logic             ev_id_ok,
  input logic             ev_sync_miss
);

  p_lock_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ev_id_ok));

  p_lock_loss_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(ev_sync_miss));

  p_out_gated_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(locked));

  p_sof_in_stream_r4: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  p_bip_step_r6: assert property (@(posedge clk) disable iff (rst)
    (bip_err_cnt >= $past(bip_err_cnt)) && ((bip_err_cnt - $past(bip_err_cnt)) <= CNT_W'(8)));

  p_len_flag_r7: assert property (@(posedge clk) disable iff (rst)
    len_crc_bad |-> len_strobe);

  p_len_count_r7: assert property (@(posedge clk) disable iff (rst)
    (len_err_cnt != $past(len_err_cnt)) |-> len_crc_bad);

  p_jump_locked_r8: assert property (@(posedge clk) disable iff (rst)
    ident_jump |-> $past(locked));

endmodule

bind ds_frame_sync ds_frame_sync_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .locked(locked), .out_valid(out_valid), .out_sof(out_sof),
  .ident_jump(ident_jump), .len_strobe(len_strobe), .len_crc_bad(len_crc_bad),
  .bip_err_cnt(bip_err_cnt), .len_err_cnt(len_err_cnt),
  .ev_id_ok(ev_id_ok), .ev_sync_miss(ev_sync_miss)
);

// File: tb/test_ds_frame_sync.sv
`timescale 1ns/1ps
module test_ds_frame_sync;

  localparam int FB = 48;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic          out_valid, out_sof, locked, ident_jump, len_strobe, len_crc_bad;
  logic [7:0]    out_byte;
  logic [15:0]   len_value;
  logic [CW-1:0] bip_err_cnt, len_err_cnt;

  ds_frame_sync #(.FRAME_BYTES(FB), .LOSS_MISSES(5), .CNT_W(CW)) i_ds_frame_sync (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof), .locked(locked),
    .ident_jump(ident_jump), .len_strobe(len_strobe), .len_value(len_value),
    .len_crc_bad(len_crc_bad), .bip_err_cnt(bip_err_cnt), .len_err_cnt(len_err_cnt)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side line model
  logic [6:0]  m_gen;
  logic [7:0]  m_par;
  // observations during one frame
  int          f_rise, f_fall, f_out_err;
  bit          f_jump, f_len, f_bad;
  logic [15:0] f_len_val;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] b_crc(input logic [15:0] w);
    logic [23:0] v;
    v = {w, 8'h00};
    for (int i = 23; i >= 8; i--) if (v[i]) v = v ^ (24'h000107 << (i - 8));
    return v[7:0];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    m_par = 8'h00;
    m_gen = 7'h7F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gap);
    if (gap) begin
      in_valid = 1'b0;
      in_byte  = 8'hA5;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic filler(input int n);
    for (int i = 0; i < n; i++) begin
      send_byte(8'h00, 1'b0);
      m_par = m_par ^ 8'h00;
    end
  endtask

  task automatic send_frame(input logic [31:0] idw, input bit bad_sync, input logic [7:0] par_flip,
                            input logic [15:0] len, input logic [7:0] crc_flip,
                            input bit gaps, input bit check_out);
    logic [31:0] sw;
    logic [7:0]  plain, key, line;
    bit          was_locked;
    f_rise = -1; f_fall = -1; f_out_err = 0;
    f_jump = 0; f_len = 0; f_bad = 0; f_len_val = 16'h0;
    sw = 32'hB6AB_31E0;
    if (bad_sync) sw[23:16] = ~sw[23:16];
    for (int k = 0; k < FB; k++) begin
      case (k)
        0: plain = sw[31:24];
        1: plain = sw[23:16];
        2: plain = sw[15:8];
        3: plain = sw[7:0];
        4: plain = idw[31:24];
        5: plain = idw[23:16];
        6: plain = idw[15:8];
        7: plain = idw[7:0];
        8: plain = m_par ^ par_flip;
        9: plain = len[15:8];
        10: plain = len[7:0];
        11: plain = b_crc(len) ^ crc_flip;
        default: plain = 8'(k * 29 + 17);
      endcase
      if (k == 4) m_gen = 7'h7F;
      key = 8'h00;
      if (k >= 4) begin
        for (int b = 0; b < 8; b++) begin
          key   = {key[6:0], m_gen[6]};
          m_gen = {m_gen[5:0], m_gen[6] ^ m_gen[5]};
        end
      end
      line = plain ^ key;
      if (k == 8) m_par = 8'h00;
      else        m_par = m_par ^ line;
      was_locked = locked;
      send_byte(line, gaps && (k % 7 == 5));
      if (!was_locked && locked && f_rise < 0) f_rise = k;
      if (was_locked && !locked && f_fall < 0) f_fall = k;
      if (ident_jump) f_jump = 1;
      if (len_strobe) begin
        f_len = 1;
        f_len_val = len_value;
        if (len_crc_bad) f_bad = 1;
      end
      if (check_out && (out_valid !== 1'b1 || out_byte !== plain || out_sof !== (k == 0)))
        f_out_err++;
    end
  endtask

  task automatic good_frame(input logic [29:0] id);
    send_frame({2'b10, id}, 1'b0, 8'h00, 16'h0040, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic acquire(input logic [29:0] id);
    do_reset();
    filler(6);
    good_frame(id);
    good_frame(id + 30'd1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "locked after reset", {31'b0, locked}, 0);
    chk("R1", "bip_err_cnt after reset", {28'b0, bip_err_cnt}, 0);
    chk("R1", "len_err_cnt after reset", {28'b0, len_err_cnt}, 0);
    chk("R1", "strobes after reset", {27'b0, out_valid, out_sof, ident_jump, len_strobe, len_crc_bad}, 0);
  endtask

  task automatic t_lock();
    do_reset();
    filler(9);
    good_frame(30'd100);
    chk("R2", "not locked after one frame", {31'b0, locked}, 0);
    good_frame(30'd101);
    chk("R2", "locked after two frames", {31'b0, locked}, 1);
    chk("R2", "lock offset", f_rise, 7);
    // wrap of the 30-bit counter counts as continuity
    do_reset();
    filler(3);
    good_frame(30'h3FFF_FFFF);
    good_frame(30'h0);
    chk("R2", "lock across counter wrap", {31'b0, locked}, 1);
  endtask

  task automatic t_presync_fail();
    do_reset();
    filler(5);
    good_frame(30'd200);
    good_frame(30'd205);
    chk("R2", "no lock on ident gap", {31'b0, locked}, 0);
    good_frame(30'd206);
    chk("R2", "still hunting/presync", {31'b0, locked}, 0);
    good_frame(30'd207);
    chk("R2", "lock after recovery", {31'b0, locked}, 1);
    do_reset();
    filler(5);
    good_frame(30'd300);
    send_frame({2'b10, 30'd301}, 1'b1, 8'h00, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R2", "no lock when second sync missing", {31'b0, locked}, 0);
  endtask

  task automatic t_descramble();
    acquire(30'd40);
    send_frame({2'b10, 30'd42}, 1'b0, 8'h00, 16'h1234, 8'h00, 1'b0, 1'b1);
    chk("R4", "descrambled stream mismatches", f_out_err, 0);
    chk("R5", "length read through descrambler", {16'b0, f_len_val}, 32'h1234);
    send_frame({2'b10, 30'd43}, 1'b0, 8'h00, 16'h0777, 8'h00, 1'b1, 1'b1);
    chk("R10", "stream with idle gaps mismatches", f_out_err, 0);
    chk("R10", "no parity error with gaps", {28'b0, bip_err_cnt}, 0);
    chk("R10", "still locked with gaps", {31'b0, locked}, 1);
  endtask

  task automatic t_bip();
    acquire(30'd60);
    good_frame(30'd62);
    chk("R6", "clean parity", {28'b0, bip_err_cnt}, 0);
    send_frame({2'b10, 30'd63}, 1'b0, 8'h13, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R6", "three bit errors", {28'b0, bip_err_cnt}, 3);
    good_frame(30'd64);
    chk("R6", "window restarts after parity byte", {28'b0, bip_err_cnt}, 3);
    send_frame({2'b10, 30'd65}, 1'b0, 8'hFF, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R6", "eight more bit errors", {28'b0, bip_err_cnt}, 11);
    send_frame({2'b10, 30'd66}, 1'b0, 8'hFF, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R9", "parity counter saturates", {28'b0, bip_err_cnt}, 15);
  endtask

  task automatic t_len();
    acquire(30'd80);
    send_frame({2'b10, 30'd82}, 1'b0, 8'h00, 16'h0123, 8'h00, 1'b0, 1'b0);
    chk("R7", "strobe and good length", {15'b0, f_len, f_len_val}, {15'b0, 1'b1, 16'h0123});
    chk("R7", "no crc flag on good length", {31'b0, f_bad}, 0);
    send_frame({2'b10, 30'd83}, 1'b0, 8'h00, 16'hBEEF, 8'h40, 1'b0, 1'b0);
    chk("R7", "crc flag on bad length", {31'b0, f_bad}, 1);
    chk("R7", "len_err_cnt after one bad", {28'b0, len_err_cnt}, 1);
    send_frame({2'b10, 30'd84}, 1'b0, 8'h01, 16'h0010, 8'h01, 1'b0, 1'b0);
    chk("R7", "len_err_cnt with parity error same frame", {28'b0, len_err_cnt}, 2);
    chk("R6", "bip_err_cnt with length error same frame", {28'b0, bip_err_cnt}, 1);
  endtask

  task automatic t_jump();
    acquire(30'd500);
    good_frame(30'd502);
    chk("R8", "no alarm on increment", {31'b0, f_jump}, 0);
    good_frame(30'd900);
    chk("R8", "alarm on jump", {31'b0, f_jump}, 1);
    chk("R8", "lock kept through jump", {31'b0, locked}, 1);
    good_frame(30'd901);
    chk("R8", "new reference followed", {31'b0, f_jump}, 0);
    send_frame({2'b01, 30'd902}, 1'b0, 8'h00, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R8", "upper ident bits ignored", {31'b0, f_jump}, 0);
  endtask

  task automatic t_loss();
    acquire(30'd700);
    for (int i = 0; i < 4; i++)
      send_frame({2'b10, 30'(702 + i)}, 1'b1, 8'h00, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R3", "lock kept after four misses", {31'b0, locked}, 1);
    good_frame(30'd706);
    for (int i = 0; i < 4; i++)
      send_frame({2'b10, 30'(707 + i)}, 1'b1, 8'h00, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R3", "good frame clears miss count", {31'b0, locked}, 1);
    send_frame({2'b10, 30'd711}, 1'b1, 8'h00, 16'h0040, 8'h00, 1'b0, 1'b0);
    chk("R3", "lock lost on fifth miss", {31'b0, locked}, 0);
    chk("R3", "loss offset", f_fall, 3);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_presync_fail();
    t_descramble();
    t_bip();
    t_len();
    t_jump();
    t_loss();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule